// File: doc/BRIEF.md
# Sublabel signature successor checker

This block validates a stream of run-time control-flow signatures sent by a checked program. Each signature holds three sublabel codes and a two-bit kind tag: normal, procedure entry or procedure exit. The block keeps one reference signature. A new signature is legal when at least one of its sublabels is the cyclic successor (code plus one) of at least one sublabel of the reference. All nine pairings are compared at the same time by a small combinational array.

A legal signature becomes the new reference. An illegal one is reported and the reference stays as it was. The first signature after reset has nothing to be compared against, so it is loaded as the reference without a check. Every accepted signature produces a one-cycle result pulse that says pass or fail.

The first rejection is held in a sticky status register, together with the reason, the rejected kind and the rejected labels. Later rejections do not overwrite it. Software clears it with a clear strobe.

Top module: `sig_succ_checker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, resValid, resOk, resErr, errFlag and errCode are 0 and sigReady is 0. sigReady is 1 from the first clock edge after reset is released.
- R2: The first signature accepted after reset with a legal kind is loaded as the reference unchecked and reported as pass.
- R3: A signature is accepted on a clock edge where sigValid and sigReady are both 1. It yields exactly one result cycle, the cycle right after that edge, with exactly one of resOk and resErr set. No result is produced without an acceptance.
- R4: Sublabel slot k occupies sigLabels[8k+7:8k]. A signature passes if and only if, for some received slot j and some reference slot i, label j equals label i plus one, across all nine pairs. A label equal to a reference label, but not its successor, does not match.
- R5: The successor wraps, so the successor of 255 is 0.
- R6: A passing signature replaces the reference at its acceptance edge. A failing signature leaves the reference unchanged.
- R7: Kind encoding on sigType: 00 normal, 01 procedure entry, 10 procedure exit, 11 illegal. Kinds 00, 01 and 10 are checked identically. Kind 11 always fails with errCode 2, whatever its labels, and is never loaded.
- R8: On a rejection while errFlag is 0, the block sets errFlag and records errCode (1 for no successor match, 2 for an illegal kind), errType and errLabels. These are visible in the result cycle. While errFlag is 1, further rejections do not change the recorded status.
- R9: errClear high at an edge clears errFlag, errCode, errType and errLabels to 0. If a rejection is accepted at the same edge, that rejection is recorded instead.
- R10: sigReady stays 1, so signatures on consecutive cycles are each checked against the reference left by the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sigValid | input | 1 | Signature offered |
| sigReady | output | 1 | Block can take a signature |
| sigType | input | 2 | Signature kind |
| sigLabels | input | 24 | Three sublabels, slot 0 in the low byte |
| errClear | input | 1 | Clear the sticky error status |
| resValid | output | 1 | Result pulse |
| resOk | output | 1 | Signature passed |
| resErr | output | 1 | Signature failed |
| errFlag | output | 1 | Sticky error present |
| errCode | output | 2 | Reason for the recorded error |
| errType | output | 2 | Kind of the recorded signature |
| errLabels | output | 24 | Labels of the recorded signature |

## Verification
The bench drives matches through each slot pairing, including cross-slot pairs. A design that compared only like slots would reject these. It sends a repeat of the reference, which a checker using equality instead of succession would accept. It steps a label from 255 to 0, which a design without wrap would flag. It follows a rejection with a signature that is legal only against the old reference, which catches a design that loads the reference on failure. It also sends an illegal kind carrying matching labels, stacks a second rejection on a set sticky flag, and raises clear together with a rejection. These show wrong priority or overwriting of the recorded status directly at the status outputs.

// File: rtl/sig_succ_pkg.sv
package sig_succ_pkg;

  typedef enum logic [1:0] {
    KIND_NORMAL     = 2'b00,
    KIND_PROC_ENTRY = 2'b01,
    KIND_PROC_EXIT  = 2'b10,
    KIND_ILLEGAL    = 2'b11
  } sigKind_e;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_NO_SUCC  = 2'd1,
    ERR_BAD_KIND = 2'd2
  } errCode_e;

  typedef struct packed {
    logic loadRef;
    logic recordErr;
    logic badKind;
    logic clearErr;
  } ctrlStrobe_t;

endpackage

// File: rtl/sig_succ_dp.sv
module sig_succ_dp
  import sig_succ_pkg::*;
#(
  parameter int LAB_W   = 8,
  parameter int NUM_LAB = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic [1:0]               sigType,
  input  logic [LAB_W*NUM_LAB-1:0] sigLabels,
  output logic                     matchAny,
  output logic [LAB_W*NUM_LAB-1:0] refLabels,
  output logic                     errFlag,
  output logic [1:0]               errCode,
  output logic [1:0]               errType,
  output logic [LAB_W*NUM_LAB-1:0] errLabels
);

  localparam int SIG_W    = LAB_W * NUM_LAB;
  localparam int NUM_PAIR = NUM_LAB * NUM_LAB;

  logic [SIG_W-1:0]    refQ;
  logic [NUM_PAIR-1:0] pairHit;
  logic [LAB_W-1:0]    refSucc [NUM_LAB];
  logic [LAB_W-1:0]    rxLab   [NUM_LAB];

  // successor per reference slot, natural wrap from all ones to zero
  for (genvar i = 0; i < NUM_LAB; i++) begin : g_slot
    assign refSucc[i] = refQ[i*LAB_W +: LAB_W] + LAB_W'(1);
    assign rxLab[i]   = sigLabels[i*LAB_W +: LAB_W];
  end

  // full cross array of comparators
  for (genvar i = 0; i < NUM_LAB; i++) begin : g_ref
    for (genvar j = 0; j < NUM_LAB; j++) begin : g_rx
      assign pairHit[i*NUM_LAB + j] = (rxLab[j] == refSucc[i]);
    end
  end

  assign matchAny  = |pairHit;
  assign refLabels = refQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refQ <= '0;
    end else if (strobe.loadRef) begin
      refQ <= sigLabels;
    end
  end

  logic             errFlagQ;
  logic [1:0]       errCodeQ;
  logic [1:0]       errTypeQ;
  logic [SIG_W-1:0] errLabelsQ;
  logic             takeErr;

  assign takeErr = strobe.recordErr && (!errFlagQ || strobe.clearErr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlagQ   <= 1'b0;
      errCodeQ   <= ERR_NONE;
      errTypeQ   <= '0;
      errLabelsQ <= '0;
    end else if (takeErr) begin
      errFlagQ   <= 1'b1;
      errCodeQ   <= strobe.badKind ? ERR_BAD_KIND : ERR_NO_SUCC;
      errTypeQ   <= sigType;
      errLabelsQ <= sigLabels;
    end else if (strobe.clearErr) begin
      errFlagQ   <= 1'b0;
      errCodeQ   <= ERR_NONE;
      errTypeQ   <= '0;
      errLabelsQ <= '0;
    end
  end

  assign errFlag   = errFlagQ;
  assign errCode   = errCodeQ;
  assign errType   = errTypeQ;
  assign errLabels = errLabelsQ;

endmodule

// File: rtl/sig_succ_ctrl.sv
module sig_succ_ctrl
  import sig_succ_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sigValid,
  input  logic [1:0]  sigType,
  input  logic        matchAny,
  input  logic        errClear,
  output logic        sigReady,
  output logic        resValid,
  output logic        resOk,
  output logic        resErr,
  output ctrlStrobe_t strobe
);

  logic readyQ;
  logic haveRefQ;
  logic resValidQ;
  logic resOkQ;
  logic resErrQ;
  logic accept;
  logic kindOk;
  logic pass;

  assign accept = sigValid && readyQ;
  assign kindOk = (sigKind_e'(sigType) != KIND_ILLEGAL);
  assign pass   = kindOk && (!haveRefQ || matchAny);

  always_comb begin
    strobe.loadRef   = accept && pass;
    strobe.recordErr = accept && !pass;
    strobe.badKind   = !kindOk;
    strobe.clearErr  = errClear;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ    <= 1'b0;
      haveRefQ  <= 1'b0;
      resValidQ <= 1'b0;
      resOkQ    <= 1'b0;
      resErrQ   <= 1'b0;
    end else begin
      readyQ    <= 1'b1;
      resValidQ <= accept;
      resOkQ    <= accept && pass;
      resErrQ   <= accept && !pass;
      if (accept && pass) haveRefQ <= 1'b1;
    end
  end

  assign sigReady = readyQ;
  assign resValid = resValidQ;
  assign resOk    = resOkQ;
  assign resErr   = resErrQ;

endmodule

// File: rtl/sig_succ_checker.sv
module sig_succ_checker
  import sig_succ_pkg::*;
#(
  parameter int LAB_W   = 8,
  parameter int NUM_LAB = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sigValid,
  output logic                     sigReady,
  input  logic [1:0]               sigType,
  input  logic [LAB_W*NUM_LAB-1:0] sigLabels,
  input  logic                     errClear,
  output logic                     resValid,
  output logic                     resOk,
  output logic                     resErr,
  output logic                     errFlag,
  output logic [1:0]               errCode,
  output logic [1:0]               errType,
  output logic [LAB_W*NUM_LAB-1:0] errLabels
);

  localparam int SIG_W = LAB_W * NUM_LAB;

  ctrlStrobe_t      strobe;
  logic             matchAny;
  logic [SIG_W-1:0] refLabels;

  sig_succ_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sigValid (sigValid),
    .sigType  (sigType),
    .matchAny (matchAny),
    .errClear (errClear),
    .sigReady (sigReady),
    .resValid (resValid),
    .resOk    (resOk),
    .resErr   (resErr),
    .strobe   (strobe)
  );

  sig_succ_dp #(.LAB_W(LAB_W), .NUM_LAB(NUM_LAB)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sigType   (sigType),
    .sigLabels (sigLabels),
    .matchAny  (matchAny),
    .refLabels (refLabels),
    .errFlag   (errFlag),
    .errCode   (errCode),
    .errType   (errType),
    .errLabels (errLabels)
  );

endmodule

// File: rtl/sig_succ_sva.sv
module sig_succ_sva #(
  parameter int SIG_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             sigValid,
  input logic             sigReady,
  input logic [1:0]       sigType,
  input logic [SIG_W-1:0] sigLabels,
  input logic             errClear,
  input logic             resValid,
  input logic             resOk,
  input logic             resErr,
  input logic             errFlag,
  input logic [1:0]       errCode,
  input logic [SIG_W-1:0] refLabels
);

  // R3
  result_follows_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sigValid && sigReady) |=> resValid);

  // R3
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sigValid && sigReady) |=> !resValid);

  // R3
  verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resOk != resErr));

  // R3
  verdict_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (!resOk && !resErr));

  // R6
  reject_keeps_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resErr) |-> $stable(refLabels));

  // R6
  pass_loads_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resOk) |-> (refLabels == $past(sigLabels)));

  // R7
  illegal_kind_rejected_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sigValid && sigReady && sigType == 2'b11) |=> resErr);

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClear) |=> (errFlag && $stable(errCode)));

  // R8
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> (resValid && resErr && errCode != 2'd0));

  // R10
  ready_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    sigReady |=> sigReady);

endmodule

bind sig_succ_checker sig_succ_sva #(.SIG_W(LAB_W*NUM_LAB)) uSva (
  .clk       (clk),
  .rstN      (rstN),
  .sigValid  (sigValid),
  .sigReady  (sigReady),
  .sigType   (sigType),
  .sigLabels (sigLabels),
  .errClear  (errClear),
  .resValid  (resValid),
  .resOk     (resOk),
  .resErr    (resErr),
  .errFlag   (errFlag),
  .errCode   (errCode),
  .refLabels (refLabels)
);

// File: tb/tb_sig_succ_checker.sv
module tb_sig_succ_checker;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sigValid = 1'b0;
  logic        sigReady;
  logic [1:0]  sigType = 2'b00;
  logic [23:0] sigLabels = '0;
  logic        errClear = 1'b0;
  logic        resValid, resOk, resErr, errFlag;
  logic [1:0]  errCode, errType;
  logic [23:0] errLabels;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_succ_checker dut (
    .clk(clk), .rstN(rstN), .sigValid(sigValid), .sigReady(sigReady),
    .sigType(sigType), .sigLabels(sigLabels), .errClear(errClear),
    .resValid(resValid), .resOk(resOk), .resErr(resErr),
    .errFlag(errFlag), .errCode(errCode), .errType(errType), .errLabels(errLabels)
  );

  typedef struct packed {
    logic        ok;
    logic        flag;
    logic [1:0]  code;
    logic [1:0]  kind;
    logic [23:0] labels;
  } expItem_t;

  expItem_t expQ[$];
  int checkCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  // reference model derived from the requirements
  bit          mHave = 1'b0;
  logic [7:0]  mRef[3];
  bit          mFlag = 1'b0;
  logic [1:0]  mCode = 2'd0;
  logic [1:0]  mKind = 2'd0;
  logic [23:0] mLab = '0;

  task automatic check(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
    checkCount++;
    if (!cond) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] t, input logic [7:0] a, b, c,
                      input bit keepValid, input bit clr);
    logic [7:0] lab[3];
    bit pass, hit;
    expItem_t e;
    lab[0] = a; lab[1] = b; lab[2] = c;
    hit = 1'b0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        if (lab[j] == 8'(mRef[i] + 8'd1)) hit = 1'b1;
    pass = (t != 2'b11) && (!mHave || hit);
    if (pass) begin
      mHave = 1'b1;
      for (int k = 0; k < 3; k++) mRef[k] = lab[k];
    end
    if (!pass && (!mFlag || clr)) begin
      mFlag = 1'b1;
      mCode = (t == 2'b11) ? 2'd2 : 2'd1;
      mKind = t;
      mLab  = {c, b, a};
    end else if (clr) begin
      mFlag = 1'b0; mCode = 2'd0; mKind = 2'd0; mLab = '0;
    end
    e.ok = pass; e.flag = mFlag; e.code = mCode; e.kind = mKind; e.labels = mLab;
    expQ.push_back(e);
    sigType   = t;
    sigLabels = {c, b, a};
    sigValid  = 1'b1;
    errClear  = clr;
    @(negedge clk);
    errClear = 1'b0;
    if (!keepValid) sigValid = 1'b0;
  endtask

  task automatic clearStatus();
    errClear = 1'b1;
    mFlag = 1'b0; mCode = 2'd0; mKind = 2'd0; mLab = '0;
    @(negedge clk);
    errClear = 1'b0;
    check(errFlag == 1'b0, "R9", "errFlag after clear", errFlag, 0);
    check(errCode == 2'd0 && errLabels == 24'd0, "R9", "status after clear",
          {errCode, errLabels}, 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3", "unexpected result pulse", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(resOk == e.ok && resErr == !e.ok, "R4", "verdict ok/err",
              {resOk, resErr}, {e.ok, !e.ok});
        check(errFlag == e.flag && errCode == e.code, "R8", "sticky flag/code",
              {errFlag, errCode}, {e.flag, e.code});
        check(errType == e.kind && errLabels == e.labels, "R8", "recorded kind/labels",
              {errType, errLabels}, {e.kind, e.labels});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    mRef[0] = 0; mRef[1] = 0; mRef[2] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(resValid == 0 && errFlag == 0 && errCode == 0, "R1", "outputs in reset",
          {resValid, errFlag, errCode}, 0);
    check(sigReady == 0, "R1", "ready in reset", sigReady, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(sigReady == 1, "R1", "ready after reset", sigReady, 1);

    // R2 first load unchecked, procedure entry kind
    send(2'b01, 8'd1, 8'd10, 8'd1, 0, 0);
    // R4 normal flow, R7 kinds 00/10 treated the same
    send(2'b00, 8'd2, 8'd5, 8'd2, 0, 0);
    send(2'b00, 8'd3, 8'd3, 8'd3, 0, 0);
    send(2'b00, 8'd4, 8'd7, 8'd4, 0, 0);
    // R4 no successor -> error code 1
    send(2'b00, 8'd6, 8'd6, 8'd6, 0, 0);
    // R6 reference untouched: 8 is successor of old slot 1
    send(2'b10, 8'd8, 8'd11, 8'd8, 0, 0);
    // R5 wrap 255 -> 0
    send(2'b00, 8'd9, 8'd255, 8'd9, 0, 0);
    send(2'b00, 8'd0, 8'd0, 8'd0, 0, 0);
    // R4 cross slot pairings, R10 back to back
    send(2'b00, 8'd1, 8'd40, 8'd50, 1, 0);
    send(2'b00, 8'd60, 8'd70, 8'd51, 1, 0);
    send(2'b00, 8'd71, 8'd9, 8'd9, 0, 0);
    // R4 repeat of reference is not a successor; R8 sticky not overwritten
    send(2'b00, 8'd71, 8'd9, 8'd9, 0, 0);
    clearStatus();
    // R7 illegal kind with matching labels -> code 2
    send(2'b11, 8'd72, 8'd10, 8'd10, 0, 0);
    // R9 clear together with a rejection records the new one
    send(2'b00, 8'd200, 8'd200, 8'd200, 0, 1);
    // R6 illegal kind not loaded: 72 still successor of 71
    send(2'b00, 8'd72, 8'd72, 8'd72, 0, 0);
    // R9 clear together with a pass clears status
    send(2'b01, 8'd73, 8'd1, 8'd1, 0, 1);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R3", "all results delivered", expQ.size(), 0);
    check(resValid == 0, "R3", "no result when idle", resValid, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule